// File: doc/BRIEF.md
# Branch target generator

This block works out where program flow goes next for the unconditional jump and call instructions of a small 8-bit, accumulator-style controller with a 16-bit code address space. A byte-serial fetch stage offers the instruction one byte at a time through a valid/ready handshake. The block keeps the current program counter. It takes the opcode, decodes how many operand bytes follow, and collects them. It then forms the branch target in one of three ways: a full 16-bit address, a page-relative address, or a signed displacement.

For a call, the block first hands the return address out through a separate push port, low byte then high byte. After that it reports the finished instruction with a one-cycle done strobe, which carries the length, the target and the call and unhandled flags. The program counter takes the new value on the clock edge that ends the done cycle. Opcodes outside the group are stepped over as one-byte instructions and flagged. No status flag is produced or changed by any form.

Top module: `branch_target_gen`

## Requirements
- R1: While reset (rstN low) is asserted, pc becomes 0x0000. After release the block is ready for an opcode (fetchReady high), and pushValid and doneValid are low.
- R2: Opcode 0x02 is a three-byte long jump. The first operand byte gives target bits 15:8 and the second gives bits 7:0, so any address from 0x0000 to 0xFFFF can be reached. doneLength is 3 and doneCall is 0.
- R3: Opcode 0x12 is a three-byte long call. It forms its target the same way as 0x02, with doneLength 3 and doneCall 1.
- R4: An opcode whose bits 4:0 are 0b00001 is a two-byte absolute jump, and one whose bits 4:0 are 0b10001 is a two-byte absolute call. For both, the target is bits 15:11 of (pc + 2), then opcode bits 7:5 as target bits 10:8, then the operand byte as bits 7:0.
- R5: Opcode 0x80 is a two-byte short jump. The target is (pc + 2) plus the operand byte read as a signed two's-complement value (-128..+127), taken modulo 2^16, so it wraps across 0xFFFF and 0x0000.
- R6: For a call, the return address (pc + length) goes out on pushByte with pushValid high: first bits 7:0, then bits 15:8. Each byte is held until pushReady accepts it. doneValid rises only after both bytes are accepted, and pc does not change while the push waits.
- R7: Any other opcode takes no operand bytes. It reports doneLength 1, doneTarget pc + 1 and doneUnhandled 1, and the next fetched byte is treated as a new opcode.
- R8: doneValid is high for exactly one cycle per instruction. pc equals doneTarget from the cycle after and changes at no other time.
- R9: A byte is consumed only on a cycle where fetchValid and fetchReady are both high. fetchReady is low while a push or the done cycle is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| fetchValid | input | 1 | Fetch stage offers a code byte |
| fetchByte | input | 8 | Offered code byte |
| fetchReady | output | 1 | Block accepts the offered byte this cycle |
| pushValid | output | 1 | Return-address byte is offered |
| pushByte | output | 8 | Return-address byte (low byte first) |
| pushReady | input | 1 | Stack side accepts the pushed byte |
| doneValid | output | 1 | One-cycle strobe: instruction resolved |
| doneLength | output | 2 | Instruction length in bytes (1 to 3) |
| doneTarget | output | 16 | Next program counter |
| doneCall | output | 1 | Resolved instruction was a call |
| doneUnhandled | output | 1 | Opcode is outside the supported group |
| pc | output | 16 | Current program counter |

## Verification
The hardest cases to reach are those that depend on where the instruction sits: a short jump whose displacement crosses 0xFFFF, and an absolute jump placed so that pc and pc + 2 lie in different 2 KB pages. A page-relative target taken from the opcode's own address would be wrong only in that second case. The bench reaches both by chaining instructions: long jumps move pc to chosen spots such as 0xFFFF and 0x07FE, and the relative or absolute form is issued from there. The push back-pressure case is reached by holding pushReady low while a call's operands go in.

// File: rtl/btg_pkg.sv
package btg_pkg;

  localparam int BYTE_W    = 8;
  localparam int ADDR_W    = 2 * BYTE_W;
  localparam int PAGE_W    = 3;
  localparam int ABS_LO_W  = BYTE_W + PAGE_W;
  localparam int SEL_W     = 5;

  localparam logic [BYTE_W-1:0] OP_LONG_JMP  = 8'h02;
  localparam logic [BYTE_W-1:0] OP_LONG_CALL = 8'h12;
  localparam logic [BYTE_W-1:0] OP_REL_JMP   = 8'h80;
  localparam logic [SEL_W-1:0]  ABS_JMP_SEL  = 5'b00001;
  localparam logic [SEL_W-1:0]  ABS_CALL_SEL = 5'b10001;

  typedef enum logic [2:0] {
    K_NONE, K_LONG_JMP, K_LONG_CALL, K_ABS_JMP, K_ABS_CALL, K_REL_JMP
  } opKind_t;

  typedef enum logic [2:0] {
    S_OPC, S_OPR1, S_OPR2, S_PUSHLO, S_PUSHHI, S_DONE
  } ctlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capOp;
    logic capB1;
    logic capB2;
    logic pushHi;
    logic commitPc;
  } dpCtl_t;

  function automatic opKind_t decodeOp(input logic [BYTE_W-1:0] op);
    if (op == OP_LONG_JMP)                 return K_LONG_JMP;
    else if (op == OP_LONG_CALL)           return K_LONG_CALL;
    else if (op == OP_REL_JMP)             return K_REL_JMP;
    else if (op[SEL_W-1:0] == ABS_JMP_SEL) return K_ABS_JMP;
    else if (op[SEL_W-1:0] == ABS_CALL_SEL) return K_ABS_CALL;
    else                                   return K_NONE;
  endfunction

  function automatic logic [1:0] kindLength(input opKind_t k);
    case (k)
      K_LONG_JMP, K_LONG_CALL:          return 2'd3;
      K_ABS_JMP, K_ABS_CALL, K_REL_JMP: return 2'd2;
      default:                          return 2'd1;
    endcase
  endfunction

  function automatic logic isCallKind(input opKind_t k);
    return (k == K_LONG_CALL) || (k == K_ABS_CALL);
  endfunction

endpackage

// File: rtl/btg_datapath.sv
module btg_datapath
  import btg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [BYTE_W-1:0] inByte,
  output opKind_t           opKind,
  output logic [1:0]        length,
  output logic [ADDR_W-1:0] target,
  output logic [BYTE_W-1:0] pushByte,
  output logic [ADDR_W-1:0] pc
);

  logic [ADDR_W-1:0] pcQ;
  logic [BYTE_W-1:0] opQ, b1Q, b2Q;
  logic [ADDR_W-1:0] nextPc;
  logic [ADDR_W-1:0] relOff;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcQ <= '0;
      opQ <= '0;
      b1Q <= '0;
      b2Q <= '0;
    end else begin
      if (ctl.capOp)    opQ <= inByte;
      if (ctl.capB1)    b1Q <= inByte;
      if (ctl.capB2)    b2Q <= inByte;
      if (ctl.commitPc) pcQ <= target;
    end
  end

  assign opKind = decodeOp(opQ);
  assign length = kindLength(opKind);
  assign nextPc = pcQ + {{(ADDR_W-2){1'b0}}, length};
  assign relOff = {{(ADDR_W-BYTE_W){b1Q[BYTE_W-1]}}, b1Q};

  always_comb begin
    case (opKind)
      K_LONG_JMP, K_LONG_CALL: target = {b1Q, b2Q};
      K_ABS_JMP, K_ABS_CALL:   target = {nextPc[ADDR_W-1:ABS_LO_W],
                                         opQ[BYTE_W-1 -: PAGE_W], b1Q};
      K_REL_JMP:               target = nextPc + relOff;
      default:                 target = nextPc;
    endcase
  end

  assign pushByte = ctl.pushHi ? nextPc[ADDR_W-1:BYTE_W] : nextPc[BYTE_W-1:0];
  assign pc       = pcQ;

endmodule

// File: rtl/btg_ctrl.sv
module btg_ctrl
  import btg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              fetchValid,
  input  logic [BYTE_W-1:0] fetchByte,
  input  logic              pushReady,
  input  opKind_t           storedKind,
  output logic              fetchReady,
  output logic              pushValid,
  output logic              doneValid,
  output dpCtl_t            ctl
);

  ctlState_t stateQ, stateD;
  logic      storedCall;
  logic      storedLong;

  assign storedCall = isCallKind(storedKind);
  assign storedLong = (kindLength(storedKind) == 2'd3);

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= S_OPC;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD     = stateQ;
    ctl        = '0;
    fetchReady = 1'b0;
    pushValid  = 1'b0;
    doneValid  = 1'b0;
    case (stateQ)
      S_OPC: begin
        fetchReady = 1'b1;
        if (fetchValid) begin
          ctl.capOp = 1'b1;
          stateD = (kindLength(decodeOp(fetchByte)) == 2'd1) ? S_DONE : S_OPR1;
        end
      end
      S_OPR1: begin
        fetchReady = 1'b1;
        if (fetchValid) begin
          ctl.capB1 = 1'b1;
          if (storedLong)      stateD = S_OPR2;
          else if (storedCall) stateD = S_PUSHLO;
          else                 stateD = S_DONE;
        end
      end
      S_OPR2: begin
        fetchReady = 1'b1;
        if (fetchValid) begin
          ctl.capB2 = 1'b1;
          stateD = storedCall ? S_PUSHLO : S_DONE;
        end
      end
      S_PUSHLO: begin
        pushValid = 1'b1;
        if (pushReady) stateD = S_PUSHHI;
      end
      S_PUSHHI: begin
        pushValid  = 1'b1;
        ctl.pushHi = 1'b1;
        if (pushReady) stateD = S_DONE;
      end
      S_DONE: begin
        doneValid    = 1'b1;
        ctl.commitPc = 1'b1;
        stateD       = S_OPC;
      end
      default: stateD = S_OPC;
    endcase
  end

endmodule

// File: rtl/branch_target_gen.sv
module branch_target_gen
  import btg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              fetchValid,
  input  logic [BYTE_W-1:0] fetchByte,
  output logic              fetchReady,
  output logic              pushValid,
  output logic [BYTE_W-1:0] pushByte,
  input  logic              pushReady,
  output logic              doneValid,
  output logic [1:0]        doneLength,
  output logic [ADDR_W-1:0] doneTarget,
  output logic              doneCall,
  output logic              doneUnhandled,
  output logic [ADDR_W-1:0] pc
);

  dpCtl_t  ctl;
  opKind_t opKind;

  btg_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .fetchValid (fetchValid),
    .fetchByte  (fetchByte),
    .pushReady  (pushReady),
    .storedKind (opKind),
    .fetchReady (fetchReady),
    .pushValid  (pushValid),
    .doneValid  (doneValid),
    .ctl        (ctl)
  );

  btg_datapath i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .inByte   (fetchByte),
    .opKind   (opKind),
    .length   (doneLength),
    .target   (doneTarget),
    .pushByte (pushByte),
    .pc       (pc)
  );

  assign doneCall      = isCallKind(opKind);
  assign doneUnhandled = (opKind == K_NONE);

endmodule

// File: rtl/btg_checker.sv
module btg_checker
  import btg_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              fetchReady,
  input logic              pushValid,
  input logic [BYTE_W-1:0] pushByte,
  input logic              pushReady,
  input logic              doneValid,
  input logic [1:0]        doneLength,
  input logic [ADDR_W-1:0] doneTarget,
  input logic              doneCall,
  input logic              doneUnhandled,
  input logic [ADDR_W-1:0] pc
);

  AST_PC_RESET: assert property (@(posedge clk) !rstN |=> pc == '0); // R1

  AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !doneValid |=> $stable(pc)); // R8

  AST_PC_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> pc == $past(doneTarget)); // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid); // R8

  AST_CALL_PUSHED: assert property (@(posedge clk) disable iff (!rstN)
    doneValid && doneCall |-> $past(pushValid && pushReady)); // R6

  AST_PUSH_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    pushValid && !pushReady |=> pushValid && $stable(pushByte)); // R6

  AST_UNH_STEP: assert property (@(posedge clk) disable iff (!rstN)
    doneValid && doneUnhandled |-> doneLength == 2'd1 && doneTarget == pc + 16'd1); // R7

  AST_NO_FETCH_PUSH: assert property (@(posedge clk) disable iff (!rstN)
    !(fetchReady && (pushValid || doneValid))); // R9

endmodule

bind branch_target_gen btg_checker i_chk (
  .clk           (clk),
  .rstN          (rstN),
  .fetchReady    (fetchReady),
  .pushValid     (pushValid),
  .pushByte      (pushByte),
  .pushReady     (pushReady),
  .doneValid     (doneValid),
  .doneLength    (doneLength),
  .doneTarget    (doneTarget),
  .doneCall      (doneCall),
  .doneUnhandled (doneUnhandled),
  .pc            (pc)
);

// File: tb/test_branch_target_gen.sv
module test_branch_target_gen;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        fetchValid = 1'b0;
  logic [7:0]  fetchByte = 8'h00;
  logic        fetchReady;
  logic        pushValid;
  logic [7:0]  pushByte;
  logic        pushReady = 1'b1;
  logic        doneValid;
  logic [1:0]  doneLength;
  logic [15:0] doneTarget;
  logic        doneCall;
  logic        doneUnhandled;
  logic [15:0] pc;

  int errors = 0;
  int checks = 0;
  int doneCnt = 0;
  int pushCnt = 0;
  logic [7:0]  pushLog [0:63];
  logic [1:0]  dLen;
  logic [15:0] dTgt;
  logic        dCall, dUnh;
  logic [15:0] expPc = 16'h0000;

  always #4 clk = ~clk;

  branch_target_gen i_branch_target_gen (
    .clk(clk), .rstN(rstN), .fetchValid(fetchValid), .fetchByte(fetchByte),
    .fetchReady(fetchReady), .pushValid(pushValid), .pushByte(pushByte),
    .pushReady(pushReady), .doneValid(doneValid), .doneLength(doneLength),
    .doneTarget(doneTarget), .doneCall(doneCall), .doneUnhandled(doneUnhandled),
    .pc(pc)
  );

  always @(posedge clk) begin
    if (rstN) begin
      if (pushValid && pushReady) begin
        pushLog[pushCnt[5:0]] <= pushByte;
        pushCnt <= pushCnt + 1;
      end
      if (doneValid) begin
        dLen  <= doneLength;
        dTgt  <= doneTarget;
        dCall <= doneCall;
        dUnh  <= doneUnhandled;
        doneCnt <= doneCnt + 1;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at a negedge after the byte was taken
  task automatic sendByte(input logic [7:0] b);
    fetchValid = 1'b1;
    fetchByte  = b;
    while (!fetchReady) @(negedge clk);
    @(negedge clk);
    fetchValid = 1'b0;
  endtask

  function automatic logic [15:0] absTgt(input logic [15:0] p, input logic [7:0] op,
                                         input logic [7:0] b);
    logic [15:0] nxt;
    nxt = p + 16'd2;
    return {nxt[15:11], op[7:5], b};
  endfunction

  function automatic logic [15:0] relTgt(input logic [15:0] p, input logic [7:0] b);
    return p + 16'd2 + {{8{b[7]}}, b};
  endfunction

  task automatic runInstr(input string req, input logic [7:0] b0, input logic [7:0] b1,
                          input logic [7:0] b2, input int n, input logic [15:0] tgt,
                          input logic isCall, input logic unh);
    int d0, p0;
    logic [15:0] ret;
    d0  = doneCnt;
    p0  = pushCnt;
    ret = expPc + 16'(n);
    sendByte(b0);
    if (n > 1) sendByte(b1);
    if (n > 2) sendByte(b2);
    while (doneCnt == d0) @(negedge clk);
    chk({req, " length"}, 32'(dLen), 32'(n));
    chk({req, " target"}, 32'(dTgt), 32'(tgt));
    chk({req, " call flag"}, 32'(dCall), 32'(isCall));
    chk({req, " unhandled flag"}, 32'(dUnh), 32'(unh));
    chk({req, " R8 pc after done"}, 32'(pc), 32'(tgt));
    chk({req, " R8 single done"}, 32'(doneCnt), 32'(d0 + 1));
    if (isCall) begin
      chk({req, " R6 push count"}, 32'(pushCnt), 32'(p0 + 2));
      chk({req, " R6 push low"}, 32'(pushLog[p0[5:0]]), 32'(ret[7:0]));
      chk({req, " R6 push high"}, 32'(pushLog[6'(p0 + 1)]), 32'(ret[15:8]));
    end else begin
      chk({req, " R6 no push"}, 32'(pushCnt), 32'(p0));
    end
    expPc = tgt;
  endtask

  task automatic testReset();
    chk("R1 pc", 32'(pc), 32'h0);
    chk("R1 fetchReady", 32'(fetchReady), 32'h1);
    chk("R1 pushValid", 32'(pushValid), 32'h0);
    chk("R1 doneValid", 32'(doneValid), 32'h0);
  endtask

  task automatic testLong();
    runInstr("R2 ljmp mid", 8'h02, 8'h12, 8'h34, 3, 16'h1234, 1'b0, 1'b0);
    runInstr("R2 ljmp top", 8'h02, 8'hFF, 8'hFF, 3, 16'hFFFF, 1'b0, 1'b0);
  endtask

  task automatic testShort();
    runInstr("R5 sjmp wrap", 8'h80, 8'h05, 8'h00, 2, relTgt(expPc, 8'h05), 1'b0, 1'b0);
    runInstr("R5 sjmp back", 8'h80, 8'hFE, 8'h00, 2, relTgt(expPc, 8'hFE), 1'b0, 1'b0);
    runInstr("R5 sjmp min", 8'h80, 8'h80, 8'h00, 2, relTgt(expPc, 8'h80), 1'b0, 1'b0);
  endtask

  task automatic testAbsolute();
    runInstr("R4 ajmp page7", 8'hE1, 8'h34, 8'h00, 2, absTgt(expPc, 8'hE1, 8'h34), 1'b0, 1'b0);
    runInstr("R2 ljmp to 07FE", 8'h02, 8'h07, 8'hFE, 3, 16'h07FE, 1'b0, 1'b0);
    // pc + 2 crosses into the next 2 KB page: upper bits come from 0x0800
    runInstr("R4 ajmp page cross", 8'h21, 8'h10, 8'h00, 2, absTgt(expPc, 8'h21, 8'h10), 1'b0, 1'b0);
  endtask

  task automatic testLongCall();
    runInstr("R3 lcall", 8'h12, 8'hAB, 8'hCD, 3, 16'hABCD, 1'b1, 1'b0);
  endtask

  task automatic testFetchGap();
    int d0;
    d0 = doneCnt;
    fetchByte = 8'h02;
    repeat (5) @(negedge clk);
    chk("R9 ready while idle", 32'(fetchReady), 32'h1);
    chk("R9 pc stable without valid", 32'(pc), 32'(expPc));
    chk("R9 no done without valid", 32'(doneCnt), 32'(d0));
  endtask

  task automatic testCallStall();
    int d0, p0;
    logic [15:0] ret, tgt;
    d0  = doneCnt;
    p0  = pushCnt;
    ret = expPc + 16'd2;
    tgt = absTgt(expPc, 8'h31, 8'h55);
    pushReady = 1'b0;
    sendByte(8'h31);
    sendByte(8'h55);
    repeat (4) @(negedge clk);
    chk("R6 push offered", 32'(pushValid), 32'h1);
    chk("R6 low byte held", 32'(pushByte), 32'(ret[7:0]));
    chk("R6 pc held during push", 32'(pc), 32'(expPc));
    chk("R6 no done before push", 32'(doneCnt), 32'(d0));
    chk("R9 no fetch during push", 32'(fetchReady), 32'h0);
    pushReady = 1'b1;
    while (doneCnt == d0) @(negedge clk);
    chk("R4 acall target", 32'(dTgt), 32'(tgt));
    chk("R4 acall length", 32'(dLen), 32'h2);
    chk("R4 acall call flag", 32'(dCall), 32'h1);
    chk("R6 acall push low", 32'(pushLog[p0[5:0]]), 32'(ret[7:0]));
    chk("R6 acall push high", 32'(pushLog[6'(p0 + 1)]), 32'(ret[15:8]));
    chk("R8 pc after acall", 32'(pc), 32'(tgt));
    expPc = tgt;
  endtask

  task automatic testUnhandled();
    runInstr("R7 unhandled A5", 8'hA5, 8'h00, 8'h00, 1, expPc + 16'd1, 1'b0, 1'b1);
    runInstr("R7 unhandled 00", 8'h00, 8'h00, 8'h00, 1, expPc + 16'd1, 1'b0, 1'b1);
    runInstr("R7 next byte is opcode", 8'h80, 8'h00, 8'h00, 2, relTgt(expPc, 8'h00), 1'b0, 1'b0);
  endtask

  bit finished = 1'b0;

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testLong();
    testShort();
    testAbsolute();
    testLongCall();
    testFetchGap();
    testCallStall();
    testUnhandled();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule